// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block sits beside the control unit of a small 8-bit processor core. It decides when the core leaves normal execution to enter interrupt service, and it then runs that entry sequence one clock at a time. The sequence lasts seven cycles. Each cycle raises one strobe, which the core's datapath uses to push the return address and the status byte onto the stack and to fetch the two halves of the service vector.

The maskable request is a level, not an event. It is accepted only at an instruction boundary, and only while the interrupt-disable flag is clear. The sequence sets that flag itself, so a request line that stays low does not restart service at once. When software clears the flag again, by the clear-mask instruction or by the return-from-interrupt, a line that is still low starts a fresh sequence. A source that is never acknowledged is therefore serviced over and over.

An optional non-maskable input reacts to a falling edge. The edge is held until it is serviced, it wins over a maskable request at the same boundary, and it selects a separate vector. A parameter can remove this input entirely.

Top module: `irq_entry_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block is idle after that edge: `busy`=0, `entry_step`=0, all strobes 0 and `i_flag`=1. A non-maskable edge latched before the reset is discarded.
- R2: When `busy`=0, `insn_end`=1, `irq_n`=0 and `i_flag`=0 at a clock edge, a sequence begins: after that edge `busy`=1 and `entry_step`=0. Without `insn_end` the request is not sampled.
- R3: A maskable request never starts a sequence while `i_flag`=1.
- R4: A sequence lasts exactly 7 cycles. `entry_step` counts 0,1,2,3,4,5,6 while `busy`=1, and `busy` returns to 0 in the cycle after step 6.
- R5: The strobes are decoded from the step. `push_ret_hi` is high in step 2, `push_ret_lo` in step 3 and `push_status` in step 4. `sp_dec` is high in steps 2, 3 and 4. `fetch_vec_lo` is high in step 5 and `fetch_vec_hi` in step 6. No strobe is high while idle.
- R6: `i_flag` keeps its prior value through step 4, so the pushed status carries the old mask. From step 5 on, `i_flag` reads 1.
- R7: While idle, a pulse on `mask_clr_cli` or `mask_clr_rti` makes `i_flag` read 0 from the next cycle. While `busy`=1 these pulses are ignored.
- R8: If `irq_n` is held low and never acknowledged, every mask clear followed by a boundary starts a new 7-cycle sequence. A boundary that arrives while the mask is still set after a sequence does not start one. Once `irq_n` is high, a mask clear followed by a boundary starts nothing.
- R9: A started sequence always runs to completion, even if `irq_n` returns high part way through.
- R10: With `NMI_EN`=1, a falling edge on `nmi_n` is latched. At the next boundary it starts a sequence with `vec_nmi`=1, whatever the value of `i_flag`. Holding `nmi_n` low afterwards does not start another sequence.
- R11: When a latched non-maskable edge and an enabled maskable request meet at the same boundary, the non-maskable one is served first (`vec_nmi`=1). The maskable request is served at a later boundary with `vec_nmi`=0.
- R12: With `NMI_EN`=0, `nmi_n` never starts a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_n | input | 1 | Maskable interrupt request, level, active low |
| nmi_n | input | 1 | Non-maskable request, falling edge (unused when NMI_EN=0) |
| insn_end | input | 1 | High in the last cycle of an instruction |
| mask_clr_cli | input | 1 | Pulse: clear-mask instruction clears the disable flag |
| mask_clr_rti | input | 1 | Pulse: return-from-interrupt clears the disable flag |
| busy | output | 1 | Entry sequence in progress |
| entry_step | output | 3 | Cycle index within the sequence, 0 to 6 (0 when idle) |
| vec_nmi | output | 1 | Vector select for the current sequence: 1 non-maskable, 0 maskable |
| push_ret_hi | output | 1 | Push high byte of the return address |
| push_ret_lo | output | 1 | Push low byte of the return address |
| push_status | output | 1 | Push status byte, break bit clear |
| sp_dec | output | 1 | Decrement the stack pointer after this cycle's push |
| fetch_vec_lo | output | 1 | Fetch low byte of the service vector |
| fetch_vec_hi | output | 1 | Fetch high byte of the service vector |
| i_flag | output | 1 | Interrupt-disable flag |

## Verification
An accepted boundary shows up one clock edge later as `busy`=1 with step 0. Step k is therefore visible k+1 edges after acceptance, and the raised mask first appears in step 5. A mask-clear pulse given while idle shows up one edge later. A falling edge on `nmi_n` needs one edge to be latched before a boundary can use it. The bench drives each input one nanosecond after a rising edge, samples one nanosecond after the next rising edge, and walks through all seven steps of every sequence it starts, comparing step, strobes, vector select and mask on each cycle. The boundary decision is swept over every combination of request level, mask and boundary strobe, with a fresh reset before each case.

// File: rtl/irq_entry_pkg.sv
// Shared constants and types for the interrupt entry sequencer.
package irq_entry_pkg;

    // Length of the entry sequence in cycles and width of its index.
    localparam int unsigned SEQ_LEN = 7;
    localparam int unsigned STEP_W  = $clog2(SEQ_LEN);

    // Cycle-by-cycle meaning of the sequence; the order is the stack order.
    typedef enum logic [STEP_W-1:0] {
        ST_INT0     = STEP_W'(0),
        ST_INT1     = STEP_W'(1),
        ST_PUSH_HI  = STEP_W'(2),
        ST_PUSH_LO  = STEP_W'(3),
        ST_PUSH_PSR = STEP_W'(4),
        ST_VEC_LO   = STEP_W'(5),
        ST_VEC_HI   = STEP_W'(6)
    } entry_step_e;

    localparam entry_step_e ST_LAST = ST_VEC_HI;

    // Per-cycle control strobes towards the datapath.
    typedef struct packed {
        logic push_ret_hi;
        logic push_ret_lo;
        logic push_status;
        logic sp_dec;
        logic fetch_vec_lo;
        logic fetch_vec_hi;
    } entry_strobes_t;

endpackage

// File: rtl/irq_nmi_detect.sv
// Non-maskable request edge latch.
// Detects a falling edge on nmi_n and holds it pending until the arbiter
// takes it. Assumes nmi_n is already synchronous to clk. With NMI_EN=0
// the input is ignored and nothing is ever pending.
module irq_nmi_detect #(
    parameter bit NMI_EN = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_n,
    input  logic take_nmi,
    output logic nmi_pend
);

    generate
        if (NMI_EN) begin : g_nmi
            logic nmi_q;
            logic pend_q;
            logic fall;

            assign fall = nmi_q & ~nmi_n;

            // Track the line; during reset copy it so a held-low line makes no edge.
            always_ff @(posedge clk) begin
                nmi_q <= nmi_n;
            end

            // Pending flag: a new edge wins over the take in the same cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pend_q <= 1'b0;
                end else if (fall) begin
                    pend_q <= 1'b1;
                end else if (take_nmi) begin
                    pend_q <= 1'b0;
                end
            end

            assign nmi_pend = pend_q;
        end else begin : g_no_nmi
            logic unused_nmi;
            assign unused_nmi = ^{clk, rst_n, nmi_n, take_nmi};
            assign nmi_pend   = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/irq_entry_arbiter.sv
// Boundary arbiter.
// Decides, only while idle and only at an instruction boundary, whether a
// sequence starts and which source it serves. A pending non-maskable
// edge wins; a maskable request needs a low line and a clear mask.
module irq_entry_arbiter (
    input  logic busy,
    input  logic insn_end,
    input  logic irq_n,
    input  logic i_flag,
    input  logic nmi_pend,
    output logic start,
    output logic start_nmi
);

    logic at_boundary;
    logic irq_ok;

    // Acceptance decision, purely combinational.
    always_comb begin
        at_boundary = insn_end & ~busy;
        irq_ok      = ~irq_n & ~i_flag;
        start_nmi   = at_boundary & nmi_pend;
        start       = at_boundary & (nmi_pend | irq_ok);
    end

endmodule

// File: rtl/irq_entry_stepper.sv
// Sequence stepper.
// Runs the seven-cycle entry sequence once started and decodes the
// per-cycle strobes. Assumes start is only raised while idle.
module irq_entry_stepper
    import irq_entry_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           start_nmi,
    output logic           busy,
    output entry_step_e    step,
    output logic           vec_nmi,
    output logic           set_mask,
    output entry_strobes_t strobes
);

    // Step counter, busy flag and latched vector select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            step    <= ST_INT0;
            vec_nmi <= 1'b0;
        end else if (start) begin
            busy    <= 1'b1;
            step    <= ST_INT0;
            vec_nmi <= start_nmi;
        end else if (busy) begin
            if (step == ST_LAST) begin
                busy <= 1'b0;
                step <= ST_INT0;
            end else begin
                step <= entry_step_e'(step + STEP_W'(1));
            end
        end
    end

    // Strobe decode for the current step; everything low while idle.
    always_comb begin
        strobes = '0;
        if (busy) begin
            unique case (step)
                ST_PUSH_HI: begin
                    strobes.push_ret_hi = 1'b1;
                    strobes.sp_dec      = 1'b1;
                end
                ST_PUSH_LO: begin
                    strobes.push_ret_lo = 1'b1;
                    strobes.sp_dec      = 1'b1;
                end
                ST_PUSH_PSR: begin
                    strobes.push_status = 1'b1;
                    strobes.sp_dec      = 1'b1;
                end
                ST_VEC_LO: strobes.fetch_vec_lo = 1'b1;
                ST_VEC_HI: strobes.fetch_vec_hi = 1'b1;
                default:   strobes = '0;
            endcase
        end
    end

    // Mask is raised at the end of the status push so the old value is stored.
    assign set_mask = busy & (step == ST_PUSH_PSR);

endmodule

// File: rtl/irq_mask_flag.sv
// Interrupt-disable flag.
// Set by reset and by the sequence; cleared by mask-clear pulses only
// while no sequence is running.
module irq_mask_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic set_mask,
    input  logic clr_cli,
    input  logic clr_rti,
    output logic i_flag
);

    // Flag register with set priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            i_flag <= 1'b1;
        end else if (set_mask) begin
            i_flag <= 1'b1;
        end else if (!busy && (clr_cli || clr_rti)) begin
            i_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/irq_entry_seq.sv
// Interrupt entry sequencer, top level.
// Samples the level-sensitive maskable request and the latched
// non-maskable edge at instruction boundaries, then drives a seven-cycle
// entry sequence. Assumes all inputs are synchronous to clk.
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter bit NMI_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_n,
    input  logic              nmi_n,
    input  logic              insn_end,
    input  logic              mask_clr_cli,
    input  logic              mask_clr_rti,
    output logic              busy,
    output logic [STEP_W-1:0] entry_step,
    output logic              vec_nmi,
    output logic              push_ret_hi,
    output logic              push_ret_lo,
    output logic              push_status,
    output logic              sp_dec,
    output logic              fetch_vec_lo,
    output logic              fetch_vec_hi,
    output logic              i_flag
);

    logic           nmi_pend;
    logic           start;
    logic           start_nmi;
    logic           set_mask;
    entry_step_e    step_q;
    entry_strobes_t strb;

    irq_nmi_detect #(.NMI_EN(NMI_EN)) u_nmi (
        .clk      (clk),
        .rst_n    (rst_n),
        .nmi_n    (nmi_n),
        .take_nmi (start_nmi),
        .nmi_pend (nmi_pend)
    );

    irq_entry_arbiter u_arb (
        .busy      (busy),
        .insn_end  (insn_end),
        .irq_n     (irq_n),
        .i_flag    (i_flag),
        .nmi_pend  (nmi_pend),
        .start     (start),
        .start_nmi (start_nmi)
    );

    irq_entry_stepper u_step (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_nmi (start_nmi),
        .busy      (busy),
        .step      (step_q),
        .vec_nmi   (vec_nmi),
        .set_mask  (set_mask),
        .strobes   (strb)
    );

    irq_mask_flag u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (busy),
        .set_mask (set_mask),
        .clr_cli  (mask_clr_cli),
        .clr_rti  (mask_clr_rti),
        .i_flag   (i_flag)
    );

    // Flatten the step and strobes onto the ports.
    assign entry_step   = step_q;
    assign push_ret_hi  = strb.push_ret_hi;
    assign push_ret_lo  = strb.push_ret_lo;
    assign push_status  = strb.push_status;
    assign sp_dec       = strb.sp_dec;
    assign fetch_vec_lo = strb.fetch_vec_lo;
    assign fetch_vec_hi = strb.fetch_vec_hi;

endmodule

// File: rtl/irq_entry_chk.sv
// Protocol checker for the interrupt entry sequencer, bound to the top.
module irq_entry_chk
    import irq_entry_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              irq_n,
    input logic              insn_end,
    input logic              mask_clr_cli,
    input logic              mask_clr_rti,
    input logic              busy,
    input logic [STEP_W-1:0] entry_step,
    input logic              vec_nmi,
    input logic              push_ret_hi,
    input logic              push_ret_lo,
    input logic              push_status,
    input logic              sp_dec,
    input logic              fetch_vec_lo,
    input logic              fetch_vec_hi,
    input logic              i_flag,
    input logic              nmi_pend
);

    // R1: reset leaves the block idle, masked and with nothing pending.
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!busy && i_flag && !nmi_pend));

    // R2: an enabled request at a boundary starts at step 0.
    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && insn_end && !irq_n && !i_flag) |=> (busy && entry_step == 0));

    // R2: no boundary, no start.
    p_need_boundary_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !insn_end) |=> !busy);

    // R3: a set mask with no non-maskable edge blocks entry.
    p_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && i_flag && !nmi_pend) |=> !busy);

    // R4: the step advances by one each cycle until the last.
    p_step_adv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && entry_step != STEP_W'(SEQ_LEN - 1)) |=>
            (busy && entry_step == $past(entry_step) + STEP_W'(1)));

    // R4: the sequence ends after the last step.
    p_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && entry_step == STEP_W'(SEQ_LEN - 1)) |=> !busy);

    // R5: at most one bus strobe at a time.
    p_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({push_ret_hi, push_ret_lo, push_status, fetch_vec_lo, fetch_vec_hi}));

    // R5: nothing strobes while idle.
    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(push_ret_hi || push_ret_lo || push_status || sp_dec
                    || fetch_vec_lo || fetch_vec_hi));

    // R6: the status push raises the mask.
    p_mask_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push_status |=> i_flag);

    // R7: an idle mask clear takes effect in the next cycle.
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (mask_clr_cli || mask_clr_rti)) |=> !i_flag);

    // R7: during the sequence the mask changes only at the status push.
    p_busy_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !push_status) |=> $stable(i_flag));

    // R10 and R11: a pending non-maskable edge at a boundary is served first.
    p_nmi_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && insn_end && nmi_pend) |=> (busy && vec_nmi));

endmodule

bind irq_entry_seq irq_entry_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq_n        (irq_n),
    .insn_end     (insn_end),
    .mask_clr_cli (mask_clr_cli),
    .mask_clr_rti (mask_clr_rti),
    .busy         (busy),
    .entry_step   (entry_step),
    .vec_nmi      (vec_nmi),
    .push_ret_hi  (push_ret_hi),
    .push_ret_lo  (push_ret_lo),
    .push_status  (push_status),
    .sp_dec       (sp_dec),
    .fetch_vec_lo (fetch_vec_lo),
    .fetch_vec_hi (fetch_vec_hi),
    .i_flag       (i_flag),
    .nmi_pend     (nmi_pend)
);

// File: tb/tb_irq_entry_seq.sv
// Self-checking bench for the interrupt entry sequencer.
module tb_irq_entry_seq;
    import irq_entry_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0, irq_n = 1'b1, nmi_n = 1'b1, insn_end = 1'b0;
    logic clr_cli = 1'b0, clr_rti = 1'b0;

    logic              busy, vec_nmi, i_flag;
    logic [STEP_W-1:0] entry_step;
    logic              p_hi, p_lo, p_st, sp_dec, v_lo, v_hi;

    logic              nb_busy, nb_vec, nb_i;
    logic [STEP_W-1:0] nb_step;
    logic              nb_hi, nb_lo, nb_st, nb_sp, nb_vl, nb_vh;

    irq_entry_seq #(.NMI_EN(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .nmi_n(nmi_n),
        .insn_end(insn_end), .mask_clr_cli(clr_cli), .mask_clr_rti(clr_rti),
        .busy(busy), .entry_step(entry_step), .vec_nmi(vec_nmi),
        .push_ret_hi(p_hi), .push_ret_lo(p_lo), .push_status(p_st),
        .sp_dec(sp_dec), .fetch_vec_lo(v_lo), .fetch_vec_hi(v_hi),
        .i_flag(i_flag)
    );

    irq_entry_seq #(.NMI_EN(1'b0)) dut_nonmi (
        .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .nmi_n(nmi_n),
        .insn_end(insn_end), .mask_clr_cli(clr_cli), .mask_clr_rti(clr_rti),
        .busy(nb_busy), .entry_step(nb_step), .vec_nmi(nb_vec),
        .push_ret_hi(nb_hi), .push_ret_lo(nb_lo), .push_status(nb_st),
        .sp_dec(nb_sp), .fetch_vec_lo(nb_vl), .fetch_vec_hi(nb_vh),
        .i_flag(nb_i)
    );

    int n_chk  = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset;
        rst_n = 1'b0; irq_n = 1'b1; nmi_n = 1'b1;
        insn_end = 1'b0; clr_cli = 1'b0; clr_rti = 1'b0;
        tick; tick;
        rst_n = 1'b1;
    endtask

    task automatic pulse_cli;
        clr_cli = 1'b1; tick; clr_cli = 1'b0;
    endtask

    task automatic pulse_rti;
        clr_rti = 1'b1; tick; clr_rti = 1'b0;
    endtask

    task automatic boundary;
        insn_end = 1'b1; tick; insn_end = 1'b0;
    endtask

    function automatic logic [5:0] strobes_now();
        return {p_hi, p_lo, p_st, sp_dec, v_lo, v_hi};
    endfunction

    // Walks the 7 steps of a sequence that started at the last edge (R4 R5 R6).
    task automatic check_seq(input bit exp_nmi, input bit i0, input int release_at,
                             input int cli_at, input string tag);
        for (int k = 0; k < SEQ_LEN; k++) begin
            logic [5:0] exp_s;
            exp_s = {k == 2, k == 3, k == 4, (k >= 2 && k <= 4), k == 5, k == 6};
            chk(busy === 1'b1 && int'(entry_step) == k, {tag, " R4 step"}, int'(entry_step), k);
            chk(strobes_now() === exp_s, {tag, " R5 strobes"}, int'(strobes_now()), int'(exp_s));
            chk(vec_nmi === exp_nmi, {tag, " vector select"}, int'(vec_nmi), int'(exp_nmi));
            chk(i_flag === ((k >= 5) ? 1'b1 : i0), {tag, " R6 mask"}, int'(i_flag),
                (k >= 5) ? 1 : int'(i0));
            if (k == release_at) irq_n = 1'b1;
            if (k == cli_at) clr_cli = 1'b1;
            tick;
            clr_cli = 1'b0;
        end
        chk(busy === 1'b0 && strobes_now() === 6'b0, {tag, " R4 end"}, int'(busy), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state.
        do_reset;
        chk(busy === 1'b0 && entry_step === '0, "R1 idle", int'(busy), 0);
        chk(i_flag === 1'b1, "R1 mask set", int'(i_flag), 1);
        chk(strobes_now() === 6'b0, "R1 strobes", int'(strobes_now()), 0);

        // R2 and R3: sweep request level, mask and boundary.
        for (int ib = 0; ib < 2; ib++) begin
            for (int mk = 0; mk < 2; mk++) begin
                for (int ie = 0; ie < 2; ie++) begin
                    bit exp_go;
                    do_reset;
                    if (mk == 0) pulse_cli;
                    irq_n = ib[0];
                    insn_end = ie[0];
                    tick;
                    insn_end = 1'b0;
                    exp_go = (ie == 1) && (ib == 0) && (mk == 0);
                    chk(busy === exp_go, (mk == 1) ? "R3 masked sweep" : "R2 accept sweep",
                        int'(busy), int'(exp_go));
                    if (exp_go) check_seq(1'b0, 1'b0, -1, -1, "R2");
                end
            end
        end

        // R7: idle mask clear by either pulse.
        do_reset;
        pulse_rti;
        chk(i_flag === 1'b0, "R7 clear by return", int'(i_flag), 0);
        do_reset;
        pulse_cli;
        chk(i_flag === 1'b0, "R7 clear by instruction", int'(i_flag), 0);

        // R9 and R7: release mid-sequence, clear pulse during the sequence.
        irq_n = 1'b0;
        boundary;
        check_seq(1'b0, 1'b0, 1, 5, "R9 R7");
        chk(i_flag === 1'b1, "R7 pulse ignored while busy", int'(i_flag), 1);
        boundary;
        chk(busy === 1'b0, "R9 no restart after release", int'(busy), 0);

        // R8: unacknowledged source re-enters after each mask clear.
        do_reset;
        irq_n = 1'b0;
        for (int r = 0; r < 3; r++) begin
            if (r % 2 == 1) pulse_rti; else pulse_cli;
            boundary;
            chk(busy === 1'b1, "R8 re-entry", int'(busy), 1);
            check_seq(1'b0, 1'b0, -1, -1, "R8");
            boundary;
            chk(busy === 1'b0, "R8 masked after sequence", int'(busy), 0);
        end
        irq_n = 1'b1;
        pulse_cli;
        boundary;
        chk(busy === 1'b0, "R8 no entry after release", int'(busy), 0);

        // R10 and R12: falling edge latched, served while masked, level no retrigger.
        do_reset;
        nmi_n = 1'b0;
        tick; tick; tick;
        boundary;
        chk(busy === 1'b1 && vec_nmi === 1'b1, "R10 edge served", int'(busy), 1);
        chk(nb_busy === 1'b0, "R12 disabled input ignored", int'(nb_busy), 0);
        check_seq(1'b1, 1'b1, -1, -1, "R10");
        boundary;
        chk(busy === 1'b0, "R10 held level no retrigger", int'(busy), 0);
        chk(nb_busy === 1'b0, "R12 still idle", int'(nb_busy), 0);

        // R1: a latched edge is dropped by reset.
        do_reset;
        nmi_n = 1'b0;
        tick;
        rst_n = 1'b0;
        tick;
        rst_n = 1'b1;
        boundary;
        chk(busy === 1'b0, "R1 pending edge cleared", int'(busy), 0);

        // R11: priority of the edge over the level at the same boundary.
        do_reset;
        pulse_cli;
        irq_n = 1'b0;
        nmi_n = 1'b0;
        tick;
        boundary;
        chk(vec_nmi === 1'b1, "R11 edge first", int'(vec_nmi), 1);
        check_seq(1'b1, 1'b0, -1, -1, "R11");
        nmi_n = 1'b1;
        pulse_cli;
        boundary;
        chk(busy === 1'b1 && vec_nmi === 1'b0, "R11 level served next", int'(vec_nmi), 0);
        check_seq(1'b0, 1'b0, -1, -1, "R11");
        irq_n = 1'b1;

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule